// File: doc/BRIEF.md
# Prescaled Tick Counter with Alarm and Overflow Flags

The block keeps a 32-bit time count that advances once per tick. The ticks come from a programmable down-counting prescaler. The prescaler runs only in cycles where the slow-clock enable `tick_en_i` is high. Software reaches the block through a 16-bit register bus. The count, the prescaler reload value and the alarm value are each split into a high half and a low half.

The count, reload and alarm cannot be changed in normal operation. Software first sets a configuration bit, then writes the halves it wants to change. These writes go into staging registers. Clearing the configuration bit starts a fixed-length commit. When the commit ends, the staged values are copied into the live registers.

A write-done status bit shows when a commit is in progress. A read-synchronised flag shows that a tick boundary has passed since software last cleared it. Two sticky event flags, alarm and overflow, are each gated by their own enable. The gated flags are ORed onto a single interrupt line.

Register map, selected by `addr_i`:

| Address | Register | Contents |
|---|---|---|
| 0 | ctrl | [0] cfg, [1] alarm enable, [2] overflow enable |
| 1 | status | [0] alarm flag, [1] overflow flag, [2] sync flag, [3] write-done (read-only) |
| 2 | count high half | count bits 31:16 |
| 3 | count low half | count bits 15:0 |
| 4 | reload high field | reload bits 19:16 |
| 5 | reload low half | reload bits 15:0 |
| 6 | alarm high half | alarm bits 31:16 |
| 7 | alarm low half | alarm bits 15:0 |

Top module: `rtc_tick_counter`

## Requirements
- R1: After reset the count is 0 and status reads 0x0008: write-done is set and all flags are clear. Both alarm addresses read 0, and `irq_o` is low.
- R2: Writes to addresses 2 to 7 made while cfg is 0 have no effect.
- R3: Writes to addresses 2 to 7 made while cfg is 1 are staged only. Live values keep their old contents until cfg is written from 1 to 0. At the end of the commit, every staged group is copied into its live register.
- R4: A commit holds write-done low for exactly 3 cycles. During the commit, writes to the cfg bit are ignored.
- R5: The prescaler moves one step in each enabled cycle. A tick occurs every reload+1 enabled cycles, and each tick adds 1 to the count. When a commit loads the count, the prescaler restarts from the reload value.
- R6: The reload value is 20 bits wide. Address 4 stores and returns only bits 3:0 of the written data, as reload bits 19:16.
- R7: Writing 0 to status bit 2 clears the sync flag. The flag is set again by the next tick.
- R8: The alarm resets to 0xFFFFFFFF and is write-only. The alarm flag (status bit 0) is set when a tick makes the count equal the alarm.
- R9: The overflow flag (status bit 1) is set when a tick wraps the count from 0xFFFFFFFF to 0.
- R10: Writing 0 to a flag bit in status clears that flag. Writing 1 leaves it unchanged.
- R11: `irq_o` is high when the alarm flag and its enable (ctrl bit 1) are both set, or when the overflow flag and its enable (ctrl bit 2) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Slow-clock enable; the prescaler steps in cycles where it is high |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`; combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check properties that must hold on every cycle:
- the cfg bit is 0 whenever write-done is low;
- a commit starts only from configuration mode;
- the overflow flag rises only on a wrap to zero;
- the alarm flag rises only when the count equals the alarm;
- the interrupt line stays low when no enabled flag is set.

The bench scenarios cover behaviour that only a sequence of bus operations can show: that staged values stay invisible until the commit, that the commit takes three cycles, that cfg writes made during a commit are dropped, the prescaler restart when the count is loaded, the width of the reload high field, the alarm reset value, and the write-zero flag clears.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DW    = 16;
  localparam int unsigned CNT_W = 2 * DW;
  localparam int unsigned AW    = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_CNT_H = 3'd2,
    A_CNT_L = 3'd3,
    A_PSC_H = 3'd4,
    A_PSC_L = 3'd5,
    A_ALM_H = 3'd6,
    A_ALM_L = 3'd7
  } reg_addr_e;

  localparam int unsigned C_CFG = 0;
  localparam int unsigned C_AIE = 1;
  localparam int unsigned C_OIE = 2;
  localparam int unsigned S_AF  = 0;
  localparam int unsigned S_OF  = 1;
  localparam int unsigned S_SYN = 2;
  localparam int unsigned S_WD  = 3;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PSC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] reload_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i)                   cnt_q <= reload_i;
    else if (tick_en_i && cnt_q == '0)    cnt_q <= reload_i;
    else if (tick_en_i)                   cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = tick_en_i && !restart_i && (cnt_q == '0);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] alarm_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             alarm_hit_o,
  output logic             ovf_hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_inc;
  end

  // a commit load overrides the tick in the same cycle
  assign alarm_hit_o = tick_i && !load_i && (cnt_inc == alarm_i);
  assign ovf_hit_o   = tick_i && !load_i && (cnt_q == '1);
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned  PSC_W      = 20,
  parameter int unsigned  COMMIT_CYC = 3,
  parameter logic [PSC_W-1:0] PSC_RST = 20'h07FFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             alarm_hit_i,
  input  logic             ovf_hit_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [PSC_W-1:0] reload_o,
  output logic [CNT_W-1:0] alarm_o,
  output logic             cfg_o,
  output logic             done_o,
  output logic             aie_o,
  output logic             oie_o,
  output logic             af_o,
  output logic             of_o
);
  localparam int unsigned BW     = $clog2(COMMIT_CYC + 1);
  localparam int unsigned PHI_W  = PSC_W - DW;

  reg_addr_e        addr;
  logic             cfg_q, aie_q, oie_q, af_q, of_q, syn_q;
  logic [BW-1:0]    busy_q;
  logic             busy, fire, start, enter, stage_we, ctrl_we, stat_we;
  logic [CNT_W-1:0] cnt_stg, alm_stg, alm_q;
  logic [PSC_W-1:0] psc_stg, psc_q;
  logic             d_cnt, d_psc, d_alm;

  assign addr     = reg_addr_e'(addr_i);
  assign busy     = (busy_q != '0);
  assign fire     = (busy_q == BW'(1));
  assign ctrl_we  = we_i && (addr == A_CTRL);
  assign stat_we  = we_i && (addr == A_STAT);
  assign start    = ctrl_we && !busy && cfg_q && !wdata_i[C_CFG];
  assign enter    = ctrl_we && !busy && !cfg_q && wdata_i[C_CFG];
  assign stage_we = we_i && cfg_q && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= 1'b0; aie_q <= 1'b0; oie_q <= 1'b0;
    end else if (ctrl_we) begin
      aie_q <= wdata_i[C_AIE];
      oie_q <= wdata_i[C_OIE];
      if (!busy) cfg_q <= wdata_i[C_CFG];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    busy_q <= '0;
    else if (start) busy_q <= BW'(COMMIT_CYC);
    else if (busy)  busy_q <= busy_q - 1'b1;
  end

  // staging: seeded from live values on entry so half-writes keep the other half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_stg <= '0; psc_stg <= PSC_RST; alm_stg <= '1;
      d_cnt <= 1'b0; d_psc <= 1'b0; d_alm <= 1'b0;
    end else if (enter) begin
      cnt_stg <= cnt_i; psc_stg <= psc_q; alm_stg <= alm_q;
      d_cnt <= 1'b0; d_psc <= 1'b0; d_alm <= 1'b0;
    end else if (fire) begin
      d_cnt <= 1'b0; d_psc <= 1'b0; d_alm <= 1'b0;
    end else if (stage_we) begin
      unique case (addr)
        A_CNT_H: begin cnt_stg[CNT_W-1:DW] <= wdata_i; d_cnt <= 1'b1; end
        A_CNT_L: begin cnt_stg[DW-1:0]     <= wdata_i; d_cnt <= 1'b1; end
        A_PSC_H: begin psc_stg[PSC_W-1:DW] <= wdata_i[PHI_W-1:0]; d_psc <= 1'b1; end
        A_PSC_L: begin psc_stg[DW-1:0]     <= wdata_i; d_psc <= 1'b1; end
        A_ALM_H: begin alm_stg[CNT_W-1:DW] <= wdata_i; d_alm <= 1'b1; end
        A_ALM_L: begin alm_stg[DW-1:0]     <= wdata_i; d_alm <= 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= PSC_RST;
      alm_q <= '1;
    end else if (fire) begin
      if (d_psc) psc_q <= psc_stg;
      if (d_alm) alm_q <= alm_stg;
    end
  end

  // flags: hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q <= 1'b0; of_q <= 1'b0; syn_q <= 1'b0;
    end else begin
      if (alarm_hit_i)                      af_q <= 1'b1;
      else if (stat_we && !wdata_i[S_AF])   af_q <= 1'b0;
      if (ovf_hit_i)                        of_q <= 1'b1;
      else if (stat_we && !wdata_i[S_OF])   of_q <= 1'b0;
      if (tick_i)                           syn_q <= 1'b1;
      else if (stat_we && !wdata_i[S_SYN])  syn_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_CTRL: begin
        rdata_o[C_CFG] = cfg_q;
        rdata_o[C_AIE] = aie_q;
        rdata_o[C_OIE] = oie_q;
      end
      A_STAT: begin
        rdata_o[S_AF]  = af_q;
        rdata_o[S_OF]  = of_q;
        rdata_o[S_SYN] = syn_q;
        rdata_o[S_WD]  = !busy;
      end
      A_CNT_H: rdata_o = cnt_i[CNT_W-1:DW];
      A_CNT_L: rdata_o = cnt_i[DW-1:0];
      A_PSC_H: rdata_o = DW'(psc_q[PSC_W-1:DW]);
      A_PSC_L: rdata_o = psc_q[DW-1:0];
      default: rdata_o = '0;
    endcase
  end

  assign load_o     = fire && d_cnt;
  assign load_val_o = cnt_stg;
  assign reload_o   = (fire && d_psc) ? psc_stg : psc_q;
  assign alarm_o    = alm_q;
  assign cfg_o      = cfg_q;
  assign done_o     = !busy;
  assign aie_o      = aie_q;
  assign oie_o      = oie_q;
  assign af_o       = af_q;
  assign of_o       = of_q;
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter
  import rtc_pkg::*;
#(
  parameter int unsigned PSC_W      = 20,
  parameter int unsigned COMMIT_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [CNT_W-1:0] cnt_w, alarm_w, load_val_w;
  logic [PSC_W-1:0] reload_w;
  logic tick_w, load_w, ahit_w, ohit_w;
  logic cfg_w, done_w, aie_w, oie_w, af_w, of_w;

  rtc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .tick_en_i,
    .restart_i(load_w), .reload_i(reload_w), .tick_o(tick_w)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick_w), .load_i(load_w),
    .load_val_i(load_val_w), .alarm_i(alarm_w), .cnt_o(cnt_w),
    .alarm_hit_o(ahit_w), .ovf_hit_o(ohit_w)
  );

  rtc_regs #(.PSC_W(PSC_W), .COMMIT_CYC(COMMIT_CYC)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt_w), .tick_i(tick_w), .alarm_hit_i(ahit_w), .ovf_hit_i(ohit_w),
    .load_o(load_w), .load_val_o(load_val_w), .reload_o(reload_w),
    .alarm_o(alarm_w), .cfg_o(cfg_w), .done_o(done_w), .aie_o(aie_w),
    .oie_o(oie_w), .af_o(af_w), .of_o(of_w)
  );

  assign irq_o = (af_w && aie_w) || (of_w && oie_w);
endmodule

// File: rtl/rtc_tick_counter_chk.sv
module rtc_tick_counter_chk
  import rtc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] alarm,
  input logic             cfg,
  input logic             done,
  input logic             aie,
  input logic             oie,
  input logic             af,
  input logic             of,
  input logic             irq
);
  assert_cfg_low_in_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |-> !cfg);
  assert_commit_from_cfg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done) |-> $past(cfg));
  assert_ovf_on_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(of) |-> ($past(cnt) == '1 && cnt == '0));
  assert_alarm_on_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af) |-> (cnt == alarm));
  assert_irq_needs_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aie && !oie) |-> !irq);
  assert_irq_needs_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!af && !of) |-> !irq);
endmodule

bind rtc_tick_counter rtc_tick_counter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt(cnt_w), .alarm(alarm_w),
  .cfg(cfg_w), .done(done_w), .aie(aie_w), .oie(oie_w),
  .af(af_w), .of(of_w), .irq(irq_o)
);

// File: tb/tb_rtc_tick_counter.sv
module tb_rtc_tick_counter;
  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, CNTH = 3'd2, CNTL = 3'd3,
                         PSCH = 3'd4, PSCL = 3'd5, ALMH = 3'd6, ALML = 3'd7;

  typedef struct {
    int          kind;   // 0: rdata, 1: irq
    logic [15:0] exp;
    string       req;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;
  item_t       sb_q[$];
  int          n_cmp = 0, n_bad = 0;
  bit          over = 1'b0;

  always #10 clk = ~clk;

  rtc_tick_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb_q.pop_front();
      act = (it.kind == 1) ? {15'b0, irq} : rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [15:0] e, input string r);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.kind = 0; it.exp = e; it.req = r;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic exp_irq(input logic e, input string r);
    item_t it;
    @(posedge clk); #1;
    it.kind = 1; it.exp = {15'b0, e}; it.req = r;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!over) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    exp_rd(STAT, 16'h0008, "R1 status");
    exp_rd(CNTL, 16'h0000, "R1 count lo");
    exp_rd(ALMH, 16'h0000, "R1 R8 alarm write-only");
    exp_irq(1'b0, "R1 irq");

    wr(CNTL, 16'h0055);
    exp_rd(CNTL, 16'h0000, "R2 write outside cfg");

    wr(CTRL, 16'h0005);
    wr(PSCH, 16'h0000);
    wr(PSCL, 16'h0003);
    wr(CNTH, 16'hFFFF);
    wr(CNTL, 16'hFFFD);
    exp_rd(CNTH, 16'h0000, "R3 staged not visible");
    wr(CTRL, 16'h0004);
    exp_rd(STAT, 16'h0000, "R4 write-done low in commit");
    settle();
    exp_rd(STAT, 16'h0008, "R4 write-done back");
    exp_rd(CNTH, 16'hFFFF, "R3 count hi committed");
    exp_rd(CNTL, 16'hFFFD, "R3 count lo committed");
    exp_rd(PSCL, 16'h0003, "R3 reload committed");

    ticks(3);
    exp_rd(CNTL, 16'hFFFD, "R5 no tick before reload+1");
    ticks(1);
    exp_rd(CNTL, 16'hFFFE, "R5 tick");
    exp_rd(STAT, 16'h000C, "R7 sync set");
    wr(STAT, 16'h0000);
    exp_rd(STAT, 16'h0008, "R7 sync cleared");

    ticks(4);
    exp_rd(STAT, 16'h000D, "R8 alarm reset value match");
    exp_irq(1'b0, "R11 alarm not enabled");
    ticks(4);
    exp_rd(STAT, 16'h000F, "R9 overflow flag");
    exp_rd(CNTH, 16'h0000, "R9 wrap hi");
    exp_irq(1'b1, "R11 overflow enabled");

    wr(STAT, 16'h0005);
    exp_rd(STAT, 16'h000D, "R10 clear ovf only");
    exp_irq(1'b0, "R11 irq drops");
    wr(STAT, 16'h0004);
    exp_rd(STAT, 16'h000C, "R10 clear alarm");

    wr(CTRL, 16'h0003);
    wr(ALMH, 16'h0000);
    wr(ALML, 16'h0002);
    wr(CTRL, 16'h0002);
    settle();
    ticks(4);
    exp_irq(1'b0, "R8 no match at 1");
    ticks(4);
    exp_rd(STAT, 16'h000D, "R8 alarm flag");
    exp_irq(1'b1, "R11 alarm enabled");

    wr(STAT, 16'h0004);
    wr(CTRL, 16'h0001);
    wr(CTRL, 16'h0000);
    wr(CTRL, 16'h0001);
    settle();
    exp_rd(CTRL, 16'h0000, "R4 cfg write ignored in commit");
    wr(CNTL, 16'h0055);
    exp_rd(CNTL, 16'h0002, "R2 count unchanged");

    ticks(2);
    wr(CTRL, 16'h0001);
    wr(CNTH, 16'h0000);
    wr(CNTL, 16'h0020);
    wr(CTRL, 16'h0000);
    settle();
    ticks(3);
    exp_rd(CNTL, 16'h0020, "R5 prescaler restarted");
    ticks(1);
    exp_rd(CNTL, 16'h0021, "R5 tick after restart");

    wr(CTRL, 16'h0001);
    wr(PSCH, 16'hFFF1);
    wr(CTRL, 16'h0000);
    settle();
    exp_rd(PSCH, 16'h0001, "R6 reload high field");
    exp_rd(PSCL, 16'h0003, "R6 reload low kept");

    repeat (2) @(posedge clk);
    over = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule